// File: doc/BRIEF.md
# Programmable Parallel Port Core

This block is a bus-attached general-purpose parallel I/O device with 24 lines, arranged as two 8-bit ports (A and B) and a third 8-bit port (C) that is handled as two independent 4-bit halves. A host reaches the three ports and one command register through a chip select, separate read and write enables, a 2-bit register address and an 8-bit data bus. The pins are not tristate. Each port has a separate input vector, output vector and output-enable vector, so the pad ring can build the drivers.

Only the simple operating mode is built. In this mode a port configured as output drives a latch that holds the last value written. A port configured as input is read straight from its pins, with no capture. The command register takes two kinds of words, told apart by the top bit. One kind defines the directions of every port. The other kind sets or clears one chosen bit of port C. Direction is held per port for A and B, and per nibble for C. Group A covers port A and the upper half of C. Group B covers port B and the lower half of C.

Top module: `ppio_core`

## Requirements
- R1: After reset every line is an input: all output-enable bits are 0, all output latches are 0, and a command-register read returns 8'h9B.
- R2: When cs_n is high, writes have no effect on any latch or direction, and rdata is 8'h00. rdata is also 8'h00 whenever rd_en is low.
- R3: addr selects port A at 2'b00, port B at 2'b01, port C at 2'b10 and the command register at 2'b11. A port write lands in that port's latch only.
- R4: A command write with bit 7 = 1 defines the directions. Bit 4 sets port A, bit 3 sets C[7:4], bit 1 sets port B and bit 0 sets C[3:0], where 1 means input. Output enables are the inverse of the direction bits. Bits 6, 5 and 2 (the mode fields) are ignored, and only the simple mode is built.
- R5: A direction-defining command write clears the A, B and C output latches to 0 on the same clock edge.
- R6: A command write with bit 7 = 0 copies bit 0 into port C bit number wdata[3:1]. No other latch bit and no direction changes.
- R7: A port write updates the latch on the clock edge it is sampled at. The latch then holds that value until the next write, clear or bit update.
- R8: Reading a port, or a C nibble, that is configured as input returns the present pin value combinationally, with no capture.
- R9: Reading a port, or a C nibble, that is configured as output returns its output latch.
- R10: A command-register read returns {1, 2'b00, dirA, dirCu, 0, dirB, dirCl}.
- R11: A write to a port configured as input still updates its latch. The new value shows on the out vector while the enables stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| wr_en | input | 1 | Write enable, sampled on the clock edge |
| rd_en | input | 1 | Read enable, gates rdata |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| pa_in | input | 8 | Port A pin input |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A output enable |
| pb_in | input | 8 | Port B pin input |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B output enable |
| pc_in | input | 8 | Port C pin input |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C output enable |

## Verification
The properties assume that cs_n, wr_en, addr and wdata are known and steady across every rising edge once reset is released. They also assume that reset is held low from time zero, so that the first sampled state is the reset state. The stimulus changes every input only on the falling edge and starts with reset asserted. Its random phase draws only defined values, so the properties never see an unknown or mid-edge bus. The bit-update property indexes port C by the sampled wdata[3:1]. It therefore relies on the same word still being held in the past-value sample, and one-cycle writes give that.

// File: rtl/ppio_pkg.sv
// Shared constants for the parallel port core.
// Assumes an 8-bit host bus; ports split into equal lanes (nibbles).
package ppio_pkg;
    localparam int PORT_W    = 8;
    localparam int LANE_W    = PORT_W / 2;
    localparam int N_PORTS   = 3;
    localparam int N_LANES   = N_PORTS * 2;
    localparam int IDX_W     = $clog2(PORT_W);
    localparam int BIT_W     = $clog2(LANE_W);

    typedef enum logic [1:0] {
        SEL_A   = 2'b00,
        SEL_B   = 2'b01,
        SEL_C   = 2'b10,
        SEL_CMD = 2'b11
    } sel_e;
endpackage

// File: rtl/ppio_cmd_decode.sv
// Decodes a host write into per-port load strokes, a direction-define
// stroke and a single-bit update stroke for port C.
// Assumes cs_n/wr_en are synchronous to the core clock.
module ppio_cmd_decode
    import ppio_pkg::*;
(
    input  logic               cs_n,
    input  logic               wr_en,
    input  logic [1:0]         addr,
    input  logic               cmd_flag,
    input  logic [3:0]         dir_src,   // {A, C upper, B, C lower}
    output logic [N_PORTS-1:0] port_wr,
    output logic               mode_wr,
    output logic               bsr_wr,
    output logic [N_LANES-1:0] dir_lane
);
    logic wr_ok;
    logic cmd_sel;

    // Qualified write and command-register select
    assign wr_ok   = !cs_n && wr_en;
    assign cmd_sel = wr_ok && (addr == SEL_CMD);

    // One load stroke per data port
    for (genvar p = 0; p < N_PORTS; p++) begin : g_port_wr
        assign port_wr[p] = wr_ok && (addr == 2'(p));
    end

    // Command word kind is chosen by the flag bit
    assign mode_wr = cmd_sel && cmd_flag;
    assign bsr_wr  = cmd_sel && !cmd_flag;

    // Lane order: A lo, A hi, B lo, B hi, C lo, C hi
    assign dir_lane = {dir_src[2], dir_src[0], dir_src[1],
                       dir_src[1], dir_src[3], dir_src[3]};
endmodule

// File: rtl/ppio_lane.sv
// One nibble lane: an output latch plus its direction bit.
// A direction define wins over a load, which wins over a bit update.
module ppio_lane #(
    parameter int W    = 4,
    parameter int BW   = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          dir_in,
    input  logic          load,
    input  logic [W-1:0]  load_data,
    input  logic          bit_en,
    input  logic [BW-1:0] bit_sel,
    input  logic          bit_val,
    output logic [W-1:0]  lat,
    output logic          dir
);
    // Latch and direction update in priority order
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat <= '0;
            dir <= 1'b1;
        end else if (clr) begin
            lat <= '0;
            dir <= dir_in;
        end else if (load) begin
            lat <= load_data;
        end else if (bit_en) begin
            lat[bit_sel] <= bit_val;
        end
    end
endmodule

// File: rtl/ppio_read_mux.sv
// Read path: per lane, pins when input and latch when output;
// then port select, plus the direction summary for the command address.
// Output is zero unless a qualified read is in progress.
module ppio_read_mux
    import ppio_pkg::*;
(
    input  logic                      rd_ok,
    input  logic [1:0]                addr,
    input  logic [N_LANES*LANE_W-1:0] lat_all,
    input  logic [N_LANES*LANE_W-1:0] pin_all,
    input  logic [N_LANES-1:0]        dir_all,
    output logic [PORT_W-1:0]         rdata
);
    logic [N_LANES*LANE_W-1:0] view;

    // Per-lane source choice
    for (genvar l = 0; l < N_LANES; l++) begin : g_view
        assign view[l*LANE_W +: LANE_W] = dir_all[l] ? pin_all[l*LANE_W +: LANE_W]
                                                     : lat_all[l*LANE_W +: LANE_W];
    end

    // Address select and idle forcing
    always_comb begin
        rdata = '0;
        if (rd_ok) begin
            case (addr)
                SEL_A:   rdata = view[0*PORT_W +: PORT_W];
                SEL_B:   rdata = view[1*PORT_W +: PORT_W];
                SEL_C:   rdata = view[2*PORT_W +: PORT_W];
                default: rdata = {1'b1, 2'b00, dir_all[0], dir_all[5],
                                  1'b0, dir_all[2], dir_all[4]};
            endcase
        end
    end
endmodule

// File: rtl/ppio_core.sv
// Top of the parallel port core: three 8-bit ports built from six
// nibble lanes, simple mode only. Split in/out/enable pins, no tristate.
// Assumes a synchronous host bus and a synchronous active-low reset.
module ppio_core
    import ppio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [PORT_W-1:0] wdata,
    output logic [PORT_W-1:0] rdata,
    input  logic [PORT_W-1:0] pa_in,
    output logic [PORT_W-1:0] pa_out,
    output logic [PORT_W-1:0] pa_oe,
    input  logic [PORT_W-1:0] pb_in,
    output logic [PORT_W-1:0] pb_out,
    output logic [PORT_W-1:0] pb_oe,
    input  logic [PORT_W-1:0] pc_in,
    output logic [PORT_W-1:0] pc_out,
    output logic [PORT_W-1:0] pc_oe
);
    logic [N_PORTS-1:0]        port_wr;
    logic                      mode_wr;
    logic                      bsr_wr;
    logic [N_LANES-1:0]        dir_lane;
    logic [N_LANES-1:0]        dir_all;
    logic [N_LANES*LANE_W-1:0] lat_all;
    logic [N_LANES*LANE_W-1:0] oe_all;
    logic [N_LANES*LANE_W-1:0] pin_all;
    logic [IDX_W-1:0]          bsr_idx;

    assign bsr_idx = wdata[IDX_W:1];
    assign pin_all = {pc_in, pb_in, pa_in};

    ppio_cmd_decode u_dec (
        .cs_n     (cs_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .cmd_flag (wdata[7]),
        .dir_src  ({wdata[4], wdata[3], wdata[1], wdata[0]}),
        .port_wr  (port_wr),
        .mode_wr  (mode_wr),
        .bsr_wr   (bsr_wr),
        .dir_lane (dir_lane)
    );

    // Six lanes; only the two port C lanes accept single-bit updates
    for (genvar l = 0; l < N_LANES; l++) begin : g_lane
        localparam int PORT = l / 2;
        localparam int HALF = l % 2;
        localparam logic [IDX_W-BIT_W-1:0] HSEL = (IDX_W-BIT_W)'(HALF);
        logic bit_en;

        assign bit_en = bsr_wr && (PORT == N_PORTS-1) &&
                        (bsr_idx[IDX_W-1:BIT_W] == HSEL);

        ppio_lane #(.W(LANE_W)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (mode_wr),
            .dir_in    (dir_lane[l]),
            .load      (port_wr[PORT]),
            .load_data (wdata[HALF*LANE_W +: LANE_W]),
            .bit_en    (bit_en),
            .bit_sel   (bsr_idx[BIT_W-1:0]),
            .bit_val   (wdata[0]),
            .lat       (lat_all[l*LANE_W +: LANE_W]),
            .dir       (dir_all[l])
        );

        assign oe_all[l*LANE_W +: LANE_W] = {LANE_W{~dir_all[l]}};
    end

    ppio_read_mux u_rd (
        .rd_ok   (!cs_n && rd_en),
        .addr    (addr),
        .lat_all (lat_all),
        .pin_all (pin_all),
        .dir_all (dir_all),
        .rdata   (rdata)
    );

    // Pin fan-out per port
    assign pa_out = lat_all[0*PORT_W +: PORT_W];
    assign pb_out = lat_all[1*PORT_W +: PORT_W];
    assign pc_out = lat_all[2*PORT_W +: PORT_W];
    assign pa_oe  = oe_all[0*PORT_W +: PORT_W];
    assign pb_oe  = oe_all[1*PORT_W +: PORT_W];
    assign pc_oe  = oe_all[2*PORT_W +: PORT_W];
endmodule

// File: rtl/ppio_chk.sv
// Protocol checker for ppio_core, attached by bind.
// Assumes reset is low from time zero and inputs are steady at edges.
module ppio_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       wr_en,
    input logic       rd_en,
    input logic [1:0] addr,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic [7:0] pa_out,
    input logic [7:0] pa_oe,
    input logic [7:0] pb_out,
    input logic [7:0] pb_oe,
    input logic [7:0] pc_out,
    input logic [7:0] pc_oe
);
    // First cycle out of reset: everything an input with clear latches
    p_reset_input_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (pa_oe == 8'h00 && pb_oe == 8'h00 && pc_oe == 8'h00 &&
                           pa_out == 8'h00 && pb_out == 8'h00 && pc_out == 8'h00));

    // Deselected bus leaves all state alone
    p_deselect_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out) &&
                  $stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe)));

    // No qualified read means a quiet data bus
    p_rdata_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || !rd_en) |-> rdata == 8'h00);

    // Direction word drives the enables
    p_dir_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && wr_en && addr == 2'b11 && wdata[7]) |=>
        (pa_oe == {8{~$past(wdata[4])}} && pb_oe == {8{~$past(wdata[1])}} &&
         pc_oe == {{4{~$past(wdata[3])}}, {4{~$past(wdata[0])}}}));

    // Direction word clears the latches
    p_mode_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && wr_en && addr == 2'b11 && wdata[7]) |=>
        (pa_out == 8'h00 && pb_out == 8'h00 && pc_out == 8'h00));

    // Single-bit update lands on the chosen port C bit
    p_bit_update_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && wr_en && addr == 2'b11 && !wdata[7]) |=>
        (pc_out[$past(wdata[3:1])] == $past(wdata[0]) &&
         $stable(pa_out) && $stable(pb_out) && $stable(pc_oe)));

    // Latches hold when no write is taken
    p_latch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(!cs_n && wr_en) |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out)));

    // A port A write lands exactly next edge
    p_port_a_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && wr_en && addr == 2'b00) |=>
        (pa_out == $past(wdata) && $stable(pb_out) && $stable(pc_out)));
endmodule

bind ppio_core ppio_chk u_chk (.*);

// File: tb/sim_ppio_core.sv
`timescale 1ns/1ps
// Bench for ppio_core: behavioural reference model updated on every
// rising edge, all outputs compared every cycle on the falling edge side.
module sim_ppio_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] addr = 2'b00;
    logic [7:0] wdata = 8'h00;
    logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;
    logic [7:0] rdata, pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference state
    logic [7:0] m_a = 0, m_b = 0, m_c = 0;
    bit d_a = 1, d_cu = 1, d_b = 1, d_cl = 1;

    always #2 clk = ~clk;

    ppio_core u0 (.*);

    // Reference model: update on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_a = 0; m_b = 0; m_c = 0;
            d_a = 1; d_cu = 1; d_b = 1; d_cl = 1;
        end else if (!cs_n && wr_en) begin
            case (addr)
                2'd0: m_a = wdata;
                2'd1: m_b = wdata;
                2'd2: m_c = wdata;
                default: begin
                    if (wdata[7]) begin
                        d_a = wdata[4]; d_cu = wdata[3];
                        d_b = wdata[1]; d_cl = wdata[0];
                        m_a = 0; m_b = 0; m_c = 0;
                    end else begin
                        m_c[wdata[3:1]] = wdata[0];
                    end
                end
            endcase
        end
    end

    function automatic logic [7:0] exp_rd();
        logic [7:0] r;
        if (cs_n || !rd_en) return 8'h00;
        case (addr)
            2'd0: r = d_a ? pa_in : m_a;
            2'd1: r = d_b ? pb_in : m_b;
            2'd2: begin
                r[7:4] = d_cu ? pc_in[7:4] : m_c[7:4];
                r[3:0] = d_cl ? pc_in[3:0] : m_c[3:0];
            end
            default: r = {1'b1, 2'b00, d_a, d_cu, 1'b0, d_b, d_cl};
        endcase
        return r;
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // One bus cycle: drive at falling edge, then compare everything
    task automatic step(input bit cs, input bit wr, input bit rd,
                        input logic [1:0] a, input logic [7:0] d, input string tag);
        @(negedge clk);
        cs_n = ~cs; wr_en = wr; rd_en = rd; addr = a; wdata = d;
        #1;
        chk(tag, "rdata", rdata, exp_rd());
        chk("R7", "pa_out", pa_out, m_a);
        chk("R7", "pb_out", pb_out, m_b);
        chk("R7", "pc_out", pc_out, m_c);
        chk("R4", "pa_oe", pa_oe, {8{~d_a}});
        chk("R4", "pb_oe", pb_oe, {8{~d_b}});
        chk("R4", "pc_oe", pc_oe, {{4{~d_cu}}, {4{~d_cl}}});
    endtask

    task automatic rd_expect(input logic [1:0] a, input logic [7:0] v, input string tag);
        step(1, 0, 1, a, 8'h00, tag);
        chk(tag, "fixed value", rdata, v);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        rd_expect(2'd3, 8'h9B, "R1");
        chk("R1", "pa_oe reset", pa_oe, 8'h00);
        chk("R1", "pc_out reset", pc_out, 8'h00);
        // R8 / R3: inputs pass straight through, each address its own port
        pa_in = 8'h5A; pb_in = 8'hC3; pc_in = 8'h71;
        rd_expect(2'd0, 8'h5A, "R3");
        rd_expect(2'd1, 8'hC3, "R3");
        rd_expect(2'd2, 8'h71, "R8");
        pa_in = 8'h12;
        rd_expect(2'd0, 8'h12, "R8");
        // R11: write lands in latch while still input
        step(1, 1, 0, 2'd0, 8'h3C, "R11");
        step(0, 0, 0, 2'd0, 8'h00, "R11");
        chk("R11", "pa_out while input", pa_out, 8'h3C);
        chk("R11", "pa_oe while input", pa_oe, 8'h00);
        // R4 / R5: all outputs, latches cleared
        step(1, 1, 0, 2'd3, 8'h80, "R5");
        step(0, 0, 0, 2'd0, 8'h00, "R5");
        chk("R5", "pa_out cleared", pa_out, 8'h00);
        chk("R4", "pb_oe all out", pb_oe, 8'hFF);
        rd_expect(2'd3, 8'h80, "R10");
        // R9 / R7: outputs read back their latches
        step(1, 1, 0, 2'd0, 8'hA5, "R7");
        step(1, 1, 0, 2'd1, 8'h96, "R7");
        step(1, 1, 0, 2'd2, 8'h3C, "R7");
        rd_expect(2'd0, 8'hA5, "R9");
        rd_expect(2'd1, 8'h96, "R9");
        rd_expect(2'd2, 8'h3C, "R9");
        // R2: deselected write ignored, deselected read quiet
        step(0, 1, 0, 2'd0, 8'hFF, "R2");
        rd_expect(2'd0, 8'hA5, "R2");
        step(0, 0, 1, 2'd1, 8'h00, "R2");
        chk("R2", "rdata deselected", rdata, 8'h00);
        // R6: single-bit updates
        step(1, 1, 0, 2'd3, 8'h0F, "R6");
        step(0, 0, 0, 2'd0, 8'h00, "R6");
        chk("R6", "pc bit7 set", pc_out, 8'hBC);
        step(1, 1, 0, 2'd3, 8'h04, "R6");
        step(0, 0, 0, 2'd0, 8'h00, "R6");
        chk("R6", "pc bit2 clear", pc_out, 8'hB8);
        // R8: mixed C directions, B input
        step(1, 1, 0, 2'd3, 8'h8A, "R4");
        step(1, 1, 0, 2'd2, 8'h5F, "R7");
        pc_in = 8'hE0; pb_in = 8'h44;
        rd_expect(2'd2, 8'hEF, "R8");
        rd_expect(2'd1, 8'h44, "R8");
        rd_expect(2'd3, 8'h8A, "R10");
        // R4: mode fields ignored
        step(1, 1, 0, 2'd3, 8'hE4, "R4");
        rd_expect(2'd3, 8'h80, "R4");
        // R6: bit update leaves directions alone
        step(1, 1, 0, 2'd3, 8'h8F, "R6");
        step(1, 1, 0, 2'd3, 8'h09, "R6");
        step(0, 0, 0, 2'd0, 8'h00, "R6");
        chk("R6", "pc_oe unchanged", pc_oe, 8'h00);
        chk("R6", "pc bit4 set", pc_out, 8'h10);
        // Random traffic, model compared every cycle
        for (int i = 0; i < 400; i++) begin
            pa_in = 8'($urandom); pb_in = 8'($urandom); pc_in = 8'($urandom);
            step($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1,
                 $urandom_range(0, 1) == 1, 2'($urandom), 8'($urandom), "R7");
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule